// File: doc/BRIEF.md
# Host-to-Slave Byte Mailbox with Handshake Status

This block passes single bytes in both directions between an external host bus and a local slave processor bus. The host writes an inbound byte register that the slave reads. The slave writes an outbound byte register that the host reads. An 8-bit status register tracks the state of both sides. Two full flags let each side know when the other has placed or collected a byte. A tag bit records whether the last inbound byte was a command or data, taken from one host address bit. Five status bits carry software-defined meaning: the slave can write them and the host can only read them.

The host side uses plain I/O read and write strobes and one address bit. The slave side uses read and write strobes and a 2-bit register select. A level interrupt, gated by a slave-writable enable, tells the slave that an inbound byte is waiting.

The asynchronous active-low reset is released synchronously through a two-stage synchronizer. Both read paths are combinational from the registers. All updates take effect at the clock edge on which the strobe is sampled.

Top module: `mbox_hs`

## Requirements
- R1: After reset, every status bit, the interrupt enable, both byte registers and `slv_irq` are 0.
- R2: A host write (`host_wr`) stores `host_wdata` in the inbound register and sets status bit 1 (inbound full).
- R3: On each host write, status bit 3 takes the value of `host_addr2`, where 0 means data and 1 means command.
- R4: A slave read with select 0 returns the inbound byte and clears inbound full.
- R5: A slave write with select 1 stores the outbound byte and sets status bit 0 (outbound full). A host read with `host_addr2`=0 returns the outbound byte and clears outbound full.
- R6: A slave write with select 2 loads status bits 7..4 and bit 2 from `slv_wdata`. In the same write, `slv_wdata[0]`=0 clears outbound full and 1 leaves it unchanged. Bits 3 and 1 are not changed by this write.
- R7: A host read with `host_addr2`=1 returns the status byte and has no side effect. Host writes change no status bit other than 3 and 1.
- R8: When a flag is set and cleared in the same cycle, setting wins. This covers a slave outbound write against a host outbound read, and a host write against a slave inbound read.
- R9: `slv_irq` equals inbound full AND the interrupt enable. The enable is bit 0 of a slave write with select 3 and reads back at select 3 as {7'b0, enable}.
- R10: A byte register keeps its value until it is overwritten. Overwriting a full register replaces the byte, leaves the flag set and raises no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host I/O write strobe to the inbound register |
| host_rd | input | 1 | Host I/O read strobe |
| host_addr2 | input | 1 | Host address bit: tags writes, selects status (1) or outbound byte (0) on reads |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| slv_wr | input | 1 | Slave register write strobe |
| slv_rd | input | 1 | Slave register read strobe |
| slv_sel | input | 2 | Slave register select: 0 inbound, 1 outbound, 2 status, 3 interrupt enable |
| slv_wdata | input | 8 | Slave write data |
| slv_rdata | output | 8 | Slave read data |
| slv_irq | output | 1 | Level interrupt to the slave |

## Verification
The bound checker watches the flag behaviour on every cycle. It checks that the full flags set and clear on their strobes, that setting beats clearing, that the tag copies the address bit, that writing 1 to outbound full has no effect, that host status reads leave the status unchanged, and that an enabled host write raises the interrupt. The returned byte values can only be shown by the bench's scenarios, which track a reference model through ordered sequences. These include the 256-value sweeps of inbound bytes and of status writes, overwrite of an unread byte, and the exact read data on both buses.

// File: rtl/mbox_hs_pkg.sv
package mbox_hs_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;
  // status bit positions
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_TAG = 3;
  // software-defined bits writable by the slave: 7..4 and 2
  localparam logic [BYTE_W-1:0] USER_MASK = 8'hF4;

  typedef enum logic [SEL_W-1:0] {
    SEL_INB  = 2'd0,
    SEL_OUTB = 2'd1,
    SEL_STAT = 2'd2,
    SEL_IEN  = 2'd3
  } slv_sel_e;
endpackage

// File: rtl/mbox_hs_byte_reg.sv
module mbox_hs_byte_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (en) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/mbox_hs_status.sv
module mbox_hs_status
  import mbox_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_inb,
  input  logic              host_tag,
  input  logic              host_rd_outb,
  input  logic              slv_rd_inb,
  input  logic              slv_wr_outb,
  input  logic              slv_wr_stat,
  input  logic [BYTE_W-1:0] slv_wdata,
  output logic [BYTE_W-1:0] stat
);
  logic              ibf_q, ibf_d;
  logic              obf_q, obf_d;
  logic              tag_q, tag_d;
  logic [BYTE_W-1:0] usr_q, usr_d;

  always_comb begin
    ibf_d = ibf_q;
    if (slv_rd_inb)  ibf_d = 1'b0;
    if (host_wr_inb) ibf_d = 1'b1;

    obf_d = obf_q;
    if (host_rd_outb)                       obf_d = 1'b0;
    if (slv_wr_stat && !slv_wdata[ST_OBF])  obf_d = 1'b0;
    if (slv_wr_outb)                        obf_d = 1'b1;

    tag_d = tag_q;
    if (host_wr_inb) tag_d = host_tag;

    usr_d = usr_q;
    if (slv_wr_stat) usr_d = slv_wdata & USER_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
      tag_q <= 1'b0;
      usr_q <= '0;
    end else begin
      ibf_q <= ibf_d;
      obf_q <= obf_d;
      tag_q <= tag_d;
      usr_q <= usr_d;
    end
  end

  always_comb begin
    stat         = usr_q;
    stat[ST_OBF] = obf_q;
    stat[ST_IBF] = ibf_q;
    stat[ST_TAG] = tag_q;
  end
endmodule

// File: rtl/mbox_hs.sv
module mbox_hs
  import mbox_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr2,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              slv_wr,
  input  logic              slv_rd,
  input  logic [SEL_W-1:0]  slv_sel,
  input  logic [BYTE_W-1:0] slv_wdata,
  output logic [BYTE_W-1:0] slv_rdata,
  output logic              slv_irq
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_N-1];

  logic h_rd_outb, s_rd_inb, s_wr_outb, s_wr_stat, s_wr_ien;
  assign h_rd_outb = host_rd && !host_addr2;
  assign s_rd_inb  = slv_rd && (slv_sel_e'(slv_sel) == SEL_INB);
  assign s_wr_outb = slv_wr && (slv_sel_e'(slv_sel) == SEL_OUTB);
  assign s_wr_stat = slv_wr && (slv_sel_e'(slv_sel) == SEL_STAT);
  assign s_wr_ien  = slv_wr && (slv_sel_e'(slv_sel) == SEL_IEN);

  logic [BYTE_W-1:0] inb_q, outb_q, stat_q;
  logic              ien_q;

  mbox_hs_byte_reg #(.W(BYTE_W)) u_inb (
    .clk(clk), .rst_n(rst_core_n), .en(host_wr), .d(host_wdata), .q(inb_q));

  mbox_hs_byte_reg #(.W(BYTE_W)) u_outb (
    .clk(clk), .rst_n(rst_core_n), .en(s_wr_outb), .d(slv_wdata), .q(outb_q));

  mbox_hs_byte_reg #(.W(1)) u_ien (
    .clk(clk), .rst_n(rst_core_n), .en(s_wr_ien), .d(slv_wdata[0]), .q(ien_q));

  mbox_hs_status u_stat (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .host_wr_inb  (host_wr),
    .host_tag     (host_addr2),
    .host_rd_outb (h_rd_outb),
    .slv_rd_inb   (s_rd_inb),
    .slv_wr_outb  (s_wr_outb),
    .slv_wr_stat  (s_wr_stat),
    .slv_wdata    (slv_wdata),
    .stat         (stat_q)
  );

  assign host_rdata = host_addr2 ? stat_q : outb_q;

  always_comb begin
    case (slv_sel_e'(slv_sel))
      SEL_INB:  slv_rdata = inb_q;
      SEL_OUTB: slv_rdata = outb_q;
      SEL_STAT: slv_rdata = stat_q;
      default:  slv_rdata = {{(BYTE_W-1){1'b0}}, ien_q};
    endcase
  end

  assign slv_irq = stat_q[ST_IBF] & ien_q;
endmodule

// File: rtl/mbox_hs_chk.sv
module mbox_hs_chk
  import mbox_hs_pkg::*;
(
  input logic              clk,
  input logic              rst_core_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic              host_addr2,
  input logic              slv_wr,
  input logic              slv_rd,
  input logic [SEL_W-1:0]  slv_sel,
  input logic [BYTE_W-1:0] slv_wdata,
  input logic              slv_irq,
  input logic [BYTE_W-1:0] stat,
  input logic              ien
);
  logic w_outb, w_stat, w_ien, r_inb, r_outb;
  assign w_outb = slv_wr && slv_sel == 2'd1;
  assign w_stat = slv_wr && slv_sel == 2'd2;
  assign w_ien  = slv_wr && slv_sel == 2'd3;
  assign r_inb  = slv_rd && slv_sel == 2'd0;
  assign r_outb = host_rd && !host_addr2;

  AST_IBF_SET: assert property (@(posedge clk) disable iff (!rst_core_n)
    host_wr |=> stat[ST_IBF]);                                     // R2
  AST_TAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_core_n)
    host_wr |=> stat[ST_TAG] == $past(host_addr2));                // R3
  AST_IBF_CLR: assert property (@(posedge clk) disable iff (!rst_core_n)
    (r_inb && !host_wr) |=> !stat[ST_IBF]);                        // R4
  AST_OBF_SET: assert property (@(posedge clk) disable iff (!rst_core_n)
    w_outb |=> stat[ST_OBF]);                                      // R5
  AST_OBF_HOST_CLR: assert property (@(posedge clk) disable iff (!rst_core_n)
    (r_outb && !w_outb) |=> !stat[ST_OBF]);                        // R5
  AST_OBF_W1_NOP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (w_stat && slv_wdata[0] && !r_outb) |=> stat[ST_OBF] == $past(stat[ST_OBF])); // R6
  AST_STAT_RD_NOP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (host_rd && host_addr2 && !host_wr && !slv_wr && !slv_rd) |=> $stable(stat)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (w_outb && r_outb) |=> stat[ST_OBF]);                          // R8
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (host_wr && (ien || (w_ien && slv_wdata[0])) && !w_ien) |=> slv_irq); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ien |-> !slv_irq);                                            // R9
endmodule

bind mbox_hs mbox_hs_chk u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr2 (host_addr2),
  .slv_wr     (slv_wr),
  .slv_rd     (slv_rd),
  .slv_sel    (slv_sel),
  .slv_wdata  (slv_wdata),
  .slv_irq    (slv_irq),
  .stat       (stat_q),
  .ien        (ien_q)
);

// File: tb/mbox_hs_tb.sv
module mbox_hs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_addr2 = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       slv_wr = 1'b0, slv_rd = 1'b0;
  logic [1:0] slv_sel = '0;
  logic [7:0] slv_wdata = '0;
  logic [7:0] slv_rdata;
  logic       slv_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  logic [7:0] m_inb = '0, m_outb = '0, m_usr = '0;
  logic       m_ibf = 0, m_obf = 0, m_tag = 0, m_ien = 0;

  always #10 clk = ~clk;

  mbox_hs u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr2(host_addr2),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .slv_wr(slv_wr), .slv_rd(slv_rd), .slv_sel(slv_sel),
    .slv_wdata(slv_wdata), .slv_rdata(slv_rdata), .slv_irq(slv_irq));

  function automatic logic [7:0] m_stat();
    logic [7:0] s;
    s = m_usr & 8'hF4;
    s[3] = m_tag; s[1] = m_ibf; s[0] = m_obf;
    return s;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one bus cycle with any mix of strobes; reads checked before the edge
  task automatic step(input logic hw, input logic hr, input logic ha, input logic [7:0] hd,
                      input logic sw, input logic sr, input logic [1:0] ss,
                      input logic [7:0] sd, input string req);
    logic [7:0] exp_s;
    logic       obf_set, obf_clr, ibf_clr;
    @(negedge clk);
    host_wr = hw; host_rd = hr; host_addr2 = ha; host_wdata = hd;
    slv_wr = sw; slv_rd = sr; slv_sel = ss; slv_wdata = sd;
    #2;
    if (hr) chk(req, host_rdata, ha ? m_stat() : m_outb);
    if (sr) begin
      case (ss)
        2'd0: exp_s = m_inb;
        2'd1: exp_s = m_outb;
        2'd2: exp_s = m_stat();
        default: exp_s = {7'b0, m_ien};
      endcase
      chk(req, slv_rdata, exp_s);
    end
    @(posedge clk);
    obf_set = sw && ss == 2'd1;
    obf_clr = (hr && !ha) || (sw && ss == 2'd2 && !sd[0]);
    ibf_clr = sr && ss == 2'd0;
    if (hw) begin m_inb = hd; m_tag = ha; end
    if (obf_set) m_outb = sd;
    m_obf = obf_set ? 1'b1 : (obf_clr ? 1'b0 : m_obf);
    m_ibf = hw ? 1'b1 : (ibf_clr ? 1'b0 : m_ibf);
    if (sw && ss == 2'd2) m_usr = sd & 8'hF4;
    if (sw && ss == 2'd3) m_ien = sd[0];
    #1;
    host_wr = 0; host_rd = 0; slv_wr = 0; slv_rd = 0;
    chk({req, "/R9 irq"}, {7'b0, slv_irq}, {7'b0, m_ibf & m_ien});
  endtask

  task automatic host_stat(input string req);
    step(0, 1, 1, 8'h00, 0, 0, 2'd0, 8'h00, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 irq", {7'b0, slv_irq}, 8'h00);
    host_stat("R1 status");
    step(0, 0, 0, 0, 0, 1, 2'd3, 0, "R1 ien");
    step(0, 0, 0, 0, 0, 1, 2'd0, 0, "R1 inbound");
    step(0, 1, 0, 0, 0, 0, 2'd0, 0, "R1 outbound");

    // R2 R3 R4: every inbound byte, tag from address bit
    for (int d = 0; d < 256; d++) begin
      step(1, 0, d[2], d[7:0], 0, 0, 2'd0, 0, "R2 host write");
      host_stat("R3 tag and R2 full");
      step(0, 0, 0, 0, 0, 1, 2'd0, 0, "R4 slave read");
      step(0, 0, 0, 0, 0, 1, 2'd2, 0, "R4 full cleared");
    end

    // R9: interrupt enable gating
    step(1, 0, 0, 8'h5A, 0, 0, 2'd0, 0, "R9 disabled");
    step(0, 0, 0, 0, 1, 0, 2'd3, 8'hFF, "R9 enable on");
    step(0, 0, 0, 0, 0, 1, 2'd3, 0, "R9 enable readback");
    step(0, 0, 0, 0, 0, 1, 2'd0, 0, "R9 irq drops on read");
    step(1, 0, 1, 8'hC3, 0, 0, 2'd0, 0, "R9 irq rises");
    step(0, 0, 0, 0, 1, 0, 2'd3, 8'hFE, "R9 enable off");
    step(0, 0, 0, 0, 0, 1, 2'd0, 0, "R9 drain");

    // R5 R6 R7: every status write pattern against a full outbound byte
    for (int v = 0; v < 256; v++) begin
      step(0, 0, 0, 0, 1, 0, 2'd1, v[7:0], "R5 slave write outbound");
      step(0, 0, 0, 0, 1, 0, 2'd2, v[7:0], "R6 status write");
      host_stat("R6 status view");
      step(1, 0, v[0], 8'h11, 0, 0, 2'd0, 0, "R7 host write");
      host_stat("R7 user bits kept");
      step(0, 1, 0, 0, 0, 0, 2'd0, 0, "R5 host read outbound");
      step(0, 0, 0, 0, 0, 1, 2'd2, 0, "R5 full cleared");
      step(0, 0, 0, 0, 0, 1, 2'd0, 0, "R4 drain");
    end

    // R8: set beats clear
    step(0, 0, 0, 0, 1, 0, 2'd1, 8'hA1, "R8 prime outbound");
    step(0, 1, 0, 0, 1, 0, 2'd1, 8'hB2, "R8 host read vs slave write");
    host_stat("R8 outbound still full");
    step(1, 0, 0, 8'h33, 0, 0, 2'd0, 0, "R8 prime inbound");
    step(1, 0, 1, 8'h44, 0, 1, 2'd0, 0, "R8 host write vs slave read");
    host_stat("R8 inbound still full");

    // R10: overwrite while full, value retained
    step(1, 0, 0, 8'h77, 0, 0, 2'd0, 0, "R10 overwrite inbound");
    step(0, 0, 0, 0, 0, 1, 2'd0, 0, "R10 newest inbound");
    step(0, 0, 0, 0, 0, 1, 2'd0, 0, "R10 inbound retained");
    step(0, 0, 0, 0, 1, 0, 2'd1, 8'hE9, "R10 overwrite outbound");
    step(0, 1, 0, 0, 0, 0, 2'd0, 0, "R10 newest outbound");
    step(0, 1, 0, 0, 0, 0, 2'd0, 0, "R10 outbound retained");
    host_stat("R10 flags");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule